// File: doc/BRIEF.md
# Split-Half Gated Register File

This block is a 32-entry, 32-bit general register file with two read ports and one write port. Each entry is held as two independent 16-bit halves, a lower and an upper. Every access carries a width flag. On a 16-bit read, the upper half of that port's output is not reloaded. The wide output bus therefore keeps its previous upper bits and does not toggle. The write port always updates the lower half. It updates the upper half only when the access is 32-bit or when a separate upper-write strobe is raised.

Reads are synchronous. The address and width presented in one cycle produce data on the output registers after the next rising edge. Each half is a plain memory with no reset, so it can be mapped onto block RAM. Entry 0 is a constant zero.

Top module: `split_rf`

## Requirements
- R1: Read data appears on a port's output register one clock after its address is presented; bits 15:0 then equal the lower half of the addressed entry.
- R2: When a port's width flag is 1 (32-bit), bits 31:16 of its output equal the upper half of the addressed entry one clock later.
- R3: When a port's width flag is 0 (16-bit), bits 31:16 of its output keep the value they held before that edge.
- R4: Reading address 0 returns 0 in every half that is loaded.
- R5: A write to address 0 has no effect; entry 0 still reads as 0 afterwards.
- R6: With the write enable high and a nonzero address, bits 15:0 of the write data are stored in the lower half of the entry.
- R7: The upper half is written from bits 31:16 of the write data only when the write enable is high and either the write width flag is 1 or the upper-write strobe is 1. A 16-bit write with the strobe low leaves the upper half unchanged.
- R8: A read of the entry being written on the same edge returns the value held before that write.
- R9: While synchronous reset is high, both output registers are cleared to 0 at the clock edge.
- R10: The two read ports are independent and may read different entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| rd_a_addr | input | 5 | Port A entry select |
| rd_a_wide | input | 1 | Port A width: 1 = 32-bit, 0 = 16-bit |
| rd_a_data | output | 32 | Port A registered read data |
| rd_b_addr | input | 5 | Port B entry select |
| rd_b_wide | input | 1 | Port B width: 1 = 32-bit, 0 = 16-bit |
| rd_b_data | output | 32 | Port B registered read data |
| wr_en | input | 1 | Write enable; stores the lower half |
| wr_wide | input | 1 | Write width: 1 = 32-bit, also stores the upper half |
| wr_hi_en | input | 1 | Upper-write strobe for 16-bit writes |
| wr_addr | input | 5 | Write entry select |
| wr_data | input | 32 | Write data |

## Verification
The assertions assume that reset is held for at least one edge before traffic begins. They also assume that no entry other than 0 is read before it has been written, because the storage has no reset value. The stimulus therefore writes every nonzero entry with a 32-bit write right after reset. Only after that does it start mixed-width reads and writes. Random traffic keeps all control inputs at known 0/1 values. Hold checks on the upper output bits count only edges after reset is released.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int unsigned RF_DEPTH_DEF = 32;
  localparam int unsigned RF_HALF_DEF  = 16;
  localparam int unsigned RF_RDPORTS   = 2;

  typedef enum logic {
    ACC_NARROW = 1'b0,
    ACC_WIDE   = 1'b1
  } acc_width_e;
endpackage

// File: rtl/rfs_wr_decode.sv
module rfs_wr_decode #(
  parameter int unsigned AW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  rfs_pkg::acc_width_e  wr_width,
  input  logic                 wr_hi_en,
  input  logic [AW-1:0]        wr_addr,
  output logic                 lo_we,
  output logic                 hi_we
);
  import rfs_pkg::*;

  logic addr_live;
  logic hi_gate;

  assign addr_live = (wr_addr != '0);
  assign hi_gate   = (wr_width == ACC_WIDE) | wr_hi_en;
  assign lo_we     = wr_en & addr_live;
  assign hi_we     = wr_en & addr_live & hi_gate;

  p_no_zero_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_addr == '0) |-> (!lo_we && !hi_we));

  p_narrow_keeps_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_width == ACC_NARROW && !wr_hi_en) |-> !hi_we);

  p_lo_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |-> lo_we);
endmodule

// File: rtl/rfs_bank.sv
module rfs_bank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 16,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re    [NRD],
  input  logic [AW-1:0] raddr [NRD],
  output logic [W-1:0]  q     [NRD]
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        q[p] <= '0;
      end else if (re[p]) begin
        q[p] <= (raddr[p] == '0) ? '0 : mem[raddr[p]];
      end
    end

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !re[p] |=> $stable(q[p]));

    p_zero_entry_r4: assert property (@(posedge clk) disable iff (rst)
      (re[p] && raddr[p] == '0) |=> (q[p] == '0));

    p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (q[p] == '0));
  end
endmodule

// File: rtl/split_rf.sv
module split_rf #(
  parameter int unsigned DEPTH = rfs_pkg::RF_DEPTH_DEF,
  parameter int unsigned HALF  = rfs_pkg::RF_HALF_DEF,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = 2 * HALF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_addr,
  input  logic          rd_a_wide,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  input  logic          rd_b_wide,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic          wr_hi_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  import rfs_pkg::*;

  localparam int unsigned NRD = RF_RDPORTS;

  logic          lo_we, hi_we;
  logic          lo_re [NRD];
  logic          hi_re [NRD];
  logic [AW-1:0] raddr [NRD];
  logic [HALF-1:0] lo_q [NRD];
  logic [HALF-1:0] hi_q [NRD];
  acc_width_e    wr_width;

  assign wr_width = wr_wide ? ACC_WIDE : ACC_NARROW;

  assign raddr[0] = rd_a_addr;
  assign raddr[1] = rd_b_addr;
  assign lo_re[0] = 1'b1;
  assign lo_re[1] = 1'b1;
  assign hi_re[0] = rd_a_wide;
  assign hi_re[1] = rd_b_wide;

  rfs_wr_decode #(.AW(AW)) i_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_width (wr_width),
    .wr_hi_en (wr_hi_en),
    .wr_addr  (wr_addr),
    .lo_we    (lo_we),
    .hi_we    (hi_we)
  );

  rfs_bank #(.DEPTH(DEPTH), .W(HALF), .NRD(NRD)) i_lo (
    .clk   (clk),
    .rst   (rst),
    .we    (lo_we),
    .waddr (wr_addr),
    .wdata (wr_data[HALF-1:0]),
    .re    (lo_re),
    .raddr (raddr),
    .q     (lo_q)
  );

  rfs_bank #(.DEPTH(DEPTH), .W(HALF), .NRD(NRD)) i_hi (
    .clk   (clk),
    .rst   (rst),
    .we    (hi_we),
    .waddr (wr_addr),
    .wdata (wr_data[DW-1:HALF]),
    .re    (hi_re),
    .raddr (raddr),
    .q     (hi_q)
  );

  assign rd_a_data = {hi_q[0], lo_q[0]};
  assign rd_b_data = {hi_q[1], lo_q[1]};

  p_narrow_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_a_wide |=> $stable(rd_a_data[DW-1:HALF]));

  p_port_b_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == '0) |=> (rd_b_data[HALF-1:0] == '0));
endmodule

// File: tb/test_split_rf.sv
module test_split_rf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic        rd_a_wide = 1'b0, rd_b_wide = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, wr_hi_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] m_lo [32];
  logic [15:0] m_hi [32];
  logic [31:0] exp_a = '0, exp_b = '0;

  always #2.5 clk = ~clk;

  split_rf i_split_rf (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_wide(rd_a_wide), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_wide(rd_b_wide), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_hi_en(wr_hi_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] a, input logic wide,
                                             input logic [31:0] prev);
    logic [31:0] r;
    r[15:0]  = (a == 0) ? 16'h0 : m_lo[a];
    r[31:16] = wide ? ((a == 0) ? 16'h0 : m_hi[a]) : prev[31:16];
    return r;
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [4:0] aa, input logic aw, input logic [4:0] ba, input logic bw,
                      input logic we, input logic ww, input logic wh, input logic [4:0] wa,
                      input logic [31:0] wd, input string tag);
    string ta, tb;
    rd_a_addr = aa; rd_a_wide = aw; rd_b_addr = ba; rd_b_wide = bw;
    wr_en = we; wr_wide = ww; wr_hi_en = wh; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    exp_a = model_read(aa, aw, exp_a);
    exp_b = model_read(ba, bw, exp_b);
    if (we && wa != 0) begin
      m_lo[wa] = wd[15:0];
      if (ww || wh) m_hi[wa] = wd[31:16];
    end
    @(negedge clk);
    ta = tag; tb = tag;
    if (tag == "") begin
      ta = (aa == 0) ? "R4" : (we && wa == aa) ? "R8" : aw ? "R2" : "R3";
      tb = (ba == 0) ? "R4" : (we && wa == ba) ? "R8" : bw ? "R2" : "R3";
    end
    check({ta, " port A"}, rd_a_data, exp_a);
    check({tb, " port B"}, rd_b_data, exp_b);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 reset port A", rd_a_data, 32'h0);
    check("R9 reset port B", rd_b_data, 32'h0);
    rst = 1'b0;
    exp_a = '0; exp_b = '0;

    // fill every nonzero entry with a 32-bit write (R6, R7)
    for (int i = 1; i < 32; i++)
      step(5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 5'(i),
           {8'(i), 8'hA5, 8'(~i), 8'(i * 3)}, "R4");

    // R1 / R10: two ports read different entries
    step(5'd3, 1'b1, 5'd17, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R10");
    step(5'd31, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R1");

    // R5: write to entry 0 is dropped
    step(5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0, 32'hFFFF_FFFF, "R5");
    step(5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R5");
    check("R5 entry 0 after write", rd_a_data, 32'h0);

    // R7: narrow write without strobe keeps the upper half
    step(5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd5, 32'hAAAA_5555, "R6");
    step(5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5, 32'h1234_BEEF, "R7");
    step(5'd5, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R7");
    check("R7 upper kept", rd_a_data, 32'hAAAA_BEEF);
    // narrow write with strobe updates the upper half
    step(5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd5, 32'h0000_1111, "R7");
    step(5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R7");
    check("R7 upper written by strobe", rd_a_data, 32'h0000_1111);

    // R8: same-edge read of the written entry returns the old value
    step(5'd9, 1'b1, 5'd9, 1'b0, 1'b1, 1'b1, 1'b0, 5'd9, 32'hDEAD_C0DE, "R8");
    step(5'd9, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R6");

    // R3: narrow read after a wide read keeps the upper bus bits
    step(5'd9, 1'b1, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R2");
    step(5'd7, 1'b0, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, "R3");
    check("R3 upper held", rd_a_data[31:16], 32'hDEAD);

    // mixed random traffic
    for (int k = 0; k < 3000; k++)
      step(5'($urandom), 1'($urandom), 5'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), $urandom, "");

    // R9 again mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 reset mid-run A", rd_a_data, 32'h0);
    check("R9 reset mid-run B", rd_b_data, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule